// File: doc/BRIEF.md
# GPIO Bank Controller with Interrupt Detection

This block controls one bank of general-purpose pins. Each pin has its own control word, reached over a simple single-cycle register bus. The control word selects the pin direction and its output value, enables a pull resistor and chooses its direction, and sets how the pin raises an interrupt. The same word reads back the current pin level. A bank-wide pending register shows one bit per pin. A pad-select register decides, pin by pin, whether the pad belongs to the GPIO logic or is passed to an alternate function.

Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised level with a copy delayed by one cycle. Each pin supports five trigger modes: rising edge, falling edge, both edges, level-high and level-low. These are coded in three control bits. Software acknowledges an edge interrupt by writing back the control word it read, since the pending bit is write-one-to-clear. The bank raises a single registered interrupt line whenever any pin is both enabled and pending.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control word reads zero apart from the DATA_IN bit, the pending register and the pad-select register read zero, irq_o is 0 and pad_oe is 0 while alt_oe is 0.
- R2: The address map is fixed: control word n at address n (0..NUM_PINS-1), the pending register at NUM_PINS and the pad-select register at NUM_PINS+1. Read data appears on bus_rdata one cycle after bus_rd.
- R3: Control word bits: 0 LOW, 1 HIGH, 2 TYPE, 3 interrupt enable, 4 pending (write-one-to-clear), 5 output enable, 6 output data, 7 pin level (read-only), 8 pull enable, 9 pull direction (1 = up, 0 = down). When a pad is given to GPIO, pad_oe follows bit 5 and pad_out follows bit 6, both registered.
- R4: Bit 7 of a control word reads the pin level after the two-flop synchroniser.
- R5: pad_pull_en and pad_pull_up follow bits 8 and 9 of each control word.
- R6: With TYPE set, HIGH sets pending on a rising edge, LOW sets it on a falling edge, and both bits together set it on either edge. TYPE with neither bit set never raises pending.
- R7: With TYPE clear, HIGH alone makes pending follow the pin being high and LOW alone makes it follow the pin being low. A write-one-to-clear cannot clear it while the condition holds.
- R8: In edge mode, or with no mode, a control write with bit 4 set clears pending. A write with bit 4 clear leaves pending unchanged.
- R9: When an edge-mode clear and a new qualifying edge fall in the same cycle, pending ends up set.
- R10: irq_o is the registered OR over all pins of (interrupt enable AND pending). A pending pin whose enable is clear does not raise irq_o.
- R11: Bit n of the pending register is the pending bit of pin n.
- R12: Pad-select bit n at 1 gives pad n to GPIO and forces alt_in[n] to 0. At 0, pad_out[n] and pad_oe[n] follow alt_out[n] and alt_oe[n], and alt_in[n] carries the synchronised pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull_en | output | NUM_PINS | Pull resistor enables |
| pad_pull_up | output | NUM_PINS | Pull direction, 1 = up |
| alt_out | input | NUM_PINS | Alternate-function output data |
| alt_oe | input | NUM_PINS | Alternate-function output enables |
| alt_in | output | NUM_PINS | Synchronised pad level to the alternate function |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench walks every trigger code with the pin starting on either side of its threshold. A decoder that swapped HIGH and LOW, or treated TYPE backwards, would then flag the wrong transitions, or flag the level where it should wait for an edge. Directed cases target the write-back acknowledge. In level mode the pending bit must survive a clear while the level holds, and a design that cleared it would lose a live request. A write with the pending bit at zero must not acknowledge. A clear that lands in the same cycle as a fresh edge must keep pending set, and a design that gave the clear priority would silently drop that interrupt. Masking is also checked: pending must still show in the bank register while irq_o stays low.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned CW        = 10;
  localparam int unsigned B_LOW     = 0;
  localparam int unsigned B_HIGH    = 1;
  localparam int unsigned B_TYPE    = 2;
  localparam int unsigned B_IEN     = 3;
  localparam int unsigned B_STS     = 4;
  localparam int unsigned B_OE      = 5;
  localparam int unsigned B_DOUT    = 6;
  localparam int unsigned B_DIN     = 7;
  localparam int unsigned B_PULL_EN = 8;
  localparam int unsigned B_PULL_UP = 9;
  // bits that a control write stores (pending and pin level excluded)
  localparam logic [CW-1:0] WR_MASK = 10'b11_0110_1111;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign sync_o = stab_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (sync_o == $past(async_i, 2))); // R4
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] ctrl_o,
  output logic          sts_o,
  output logic          int_o
);
  logic [CW-1:0] cfg_q;
  logic          sts_q;
  logic          prev_q;
  logic          rise, fall, is_edge, has_sel;
  logic          edge_hit, lvl_hit, clr;

  assign rise     = sync_i & ~prev_q;
  assign fall     = ~sync_i & prev_q;
  assign is_edge  = cfg_q[B_TYPE];
  assign has_sel  = cfg_q[B_HIGH] | cfg_q[B_LOW];
  assign edge_hit = is_edge & ((cfg_q[B_HIGH] & rise) | (cfg_q[B_LOW] & fall));
  assign lvl_hit  = ~is_edge & ((cfg_q[B_HIGH] & sync_i) | (cfg_q[B_LOW] & ~sync_i));
  assign clr      = wr_i & wdata_i[B_STS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      sts_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (wr_i) cfg_q <= wdata_i & WR_MASK;
      if (is_edge)      sts_q <= edge_hit | (sts_q & ~clr);
      else if (has_sel) sts_q <= lvl_hit;
      else              sts_q <= sts_q & ~clr;
    end
  end

  always_comb begin
    ctrl_o        = cfg_q;
    ctrl_o[B_STS] = sts_q;
    ctrl_o[B_DIN] = sync_i;
  end

  assign sts_o = sts_q;
  assign int_o = cfg_q[B_IEN] & sts_q;

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[B_TYPE] && cfg_q[B_HIGH] && sync_i && !prev_q) |=> sts_o); // R9
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[B_TYPE] && cfg_q[B_LOW] && !sync_i && prev_q) |=> sts_o); // R6
  AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[B_TYPE] && cfg_q[B_HIGH] && sync_i) |=> sts_o); // R7
  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[B_TYPE] && wr_i && wdata_i[B_STS] && (sync_i == prev_q)) |=> !sts_o); // R8
endmodule

// File: rtl/gpio_bus_if.sv
module gpio_bus_if
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AW       = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic [NUM_PINS-1:0][CW-1:0]  ctrl_rd,
  input  logic [NUM_PINS-1:0]          sts_vec,
  output logic [NUM_PINS-1:0]          pin_wr,
  output logic [CW-1:0]                pin_wdata,
  output logic [NUM_PINS-1:0]          padsel_o,
  output logic [DATA_W-1:0]            bus_rdata
);
  localparam logic [AW-1:0] A_STS = AW'(NUM_PINS);
  localparam logic [AW-1:0] A_SEL = AW'(NUM_PINS + 1);

  logic [NUM_PINS-1:0] padsel_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;
  logic                wdata_unused;

  assign wdata_unused = ^bus_wdata;
  assign pin_wdata    = bus_wdata[CW-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
    assign pin_wr[i] = bus_wr && (bus_addr == AW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst)                             padsel_q <= '0;
    else if (bus_wr && bus_addr == A_SEL) padsel_q <= bus_wdata[NUM_PINS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (bus_addr == AW'(i)) rd_mux[CW-1:0] = ctrl_rd[i];
    end
    if (bus_addr == A_STS) rd_mux[NUM_PINS-1:0] = sts_vec;
    if (bus_addr == A_SEL) rd_mux[NUM_PINS-1:0] = padsel_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign padsel_o  = padsel_q;
  assign bus_rdata = rdata_q;

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R2
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AW       = $clog2(NUM_PINS + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pull_en,
  output logic [NUM_PINS-1:0] pad_pull_up,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0] alt_in,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]         pin_sync;
  logic [NUM_PINS-1:0]         pin_wr;
  logic [CW-1:0]               pin_wdata;
  logic [NUM_PINS-1:0][CW-1:0] ctrl;
  logic [NUM_PINS-1:0]         sts_vec;
  logic [NUM_PINS-1:0]         int_vec;
  logic [NUM_PINS-1:0]         ien_vec;
  logic [NUM_PINS-1:0]         padsel;
  logic [NUM_PINS-1:0]         out_q, oe_q, pen_q, pup_q, alt_q;
  logic                        irq_q;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .async_i(pad_in), .sync_o(pin_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_cell u_cell (
      .clk(clk), .rst(rst),
      .sync_i(pin_sync[i]),
      .wr_i(pin_wr[i]),
      .wdata_i(pin_wdata),
      .ctrl_o(ctrl[i]),
      .sts_o(sts_vec[i]),
      .int_o(int_vec[i])
    );
    assign ien_vec[i] = ctrl[i][B_IEN];

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[i] <= 1'b0;
        oe_q[i]  <= 1'b0;
        pen_q[i] <= 1'b0;
        pup_q[i] <= 1'b0;
        alt_q[i] <= 1'b0;
      end else begin
        out_q[i] <= padsel[i] ? ctrl[i][B_DOUT] : alt_out[i];
        oe_q[i]  <= padsel[i] ? ctrl[i][B_OE]   : alt_oe[i];
        pen_q[i] <= ctrl[i][B_PULL_EN];
        pup_q[i] <= ctrl[i][B_PULL_UP];
        alt_q[i] <= padsel[i] ? 1'b0 : pin_sync[i];
      end
    end
  end

  gpio_bus_if #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .AW(AW)) u_bus (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctrl_rd(ctrl), .sts_vec(sts_vec),
    .pin_wr(pin_wr), .pin_wdata(pin_wdata),
    .padsel_o(padsel), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |int_vec;
  end

  assign pad_out     = out_q;
  assign pad_oe      = oe_q;
  assign pad_pull_en = pen_q;
  assign pad_pull_up = pup_q;
  assign alt_in      = alt_q;
  assign irq_o       = irq_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien_vec == '0) |=> !irq_o); // R10
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    ((ien_vec & sts_vec) != '0) |=> irq_o); // R10
  AST_ALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (padsel == '0 && alt_oe == '0) |=> (pad_oe == '0)); // R12
  AST_GPIO_NO_ALT: assert property (@(posedge clk) disable iff (rst)
    (padsel == '1) |=> (alt_in == '0)); // R12
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NV = 12;
  // vector: [8:6] pin, [5:3] {TYPE,HIGH,LOW}, [2] start level, [1] end level, [0] expected pending
  localparam logic [8:0] VEC [NV] = '{
    {3'd0, 3'b110, 1'b0, 1'b1, 1'b1},
    {3'd1, 3'b110, 1'b1, 1'b0, 1'b0},
    {3'd2, 3'b101, 1'b1, 1'b0, 1'b1},
    {3'd3, 3'b101, 1'b0, 1'b1, 1'b0},
    {3'd4, 3'b111, 1'b0, 1'b1, 1'b1},
    {3'd5, 3'b111, 1'b1, 1'b0, 1'b1},
    {3'd6, 3'b010, 1'b0, 1'b1, 1'b1},
    {3'd7, 3'b010, 1'b1, 1'b0, 1'b0},
    {3'd0, 3'b001, 1'b1, 1'b0, 1'b1},
    {3'd1, 3'b001, 1'b0, 1'b1, 1'b0},
    {3'd2, 3'b000, 1'b0, 1'b1, 1'b0},
    {3'd3, 3'b100, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up, alt_in;
  logic irq_o;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;
  logic [DW-1:0] rd;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PINS(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    rdreg(0, rd);      chk("R1 ctrl0", rd, 0);
    rdreg(N, rd);      chk("R1 pending", rd, 0);
    rdreg(N + 1, rd);  chk("R1 padsel", rd, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 pad_oe", {24'd0, pad_oe}, 0);

    // R6 R7 R11 trigger table
    for (int v = 0; v < NV; v++) begin
      int p;
      logic [2:0] m;
      p = int'(VEC[v][8:6]);
      m = VEC[v][5:3];
      pad_in[p] = VEC[v][2];
      cyc(6);
      wr(p, {29'd0, m} | 32'h08);
      cyc(4);
      wr(p, {29'd0, m} | 32'h18);
      cyc(4);
      pad_in[p] = VEC[v][1];
      cyc(6);
      rdreg(p, rd);
      chk($sformatf("R6 vec%0d pending bit", v), {31'd0, rd[4]}, {31'd0, VEC[v][0]});
      chk($sformatf("R10 vec%0d irq", v), {31'd0, irq_o}, {31'd0, VEC[v][0]});
      rdreg(N, rd);
      chk($sformatf("R11 vec%0d bank pending", v), rd, {31'd0, VEC[v][0]} << p);
      wr(p, 0);
      wr(p, 32'h10);
      pad_in[p] = 1'b0;
      cyc(6);
    end

    // R7 level pending survives a clear
    pad_in[0] = 1'b1;
    wr(0, 32'h0A);
    cyc(6);
    wr(0, 32'h1A);
    rdreg(0, rd);
    chk("R7 level not cleared", {31'd0, rd[4]}, 1);
    wr(0, 0); wr(0, 32'h10); pad_in[0] = 1'b0; cyc(6);

    // R8 zero in pending bit keeps it, one clears it
    wr(1, 32'h06);
    pad_in[1] = 1'b1; cyc(6);
    wr(1, 32'h06);
    rdreg(1, rd);  chk("R8 write zero keeps", {31'd0, rd[4]}, 1);
    chk("R10 masked irq low", {31'd0, irq_o}, 0);
    rdreg(N, rd);  chk("R11 masked pin pending", rd, 32'h02);
    wr(1, 32'h0E); cyc(3);
    chk("R10 enable raises irq", {31'd0, irq_o}, 1);
    wr(1, 32'h1E); cyc(3);
    rdreg(1, rd);  chk("R8 clear", {31'd0, rd[4]}, 0);
    chk("R10 irq drops", {31'd0, irq_o}, 0);
    pad_in[1] = 1'b0; cyc(6);

    // R9 clear and new edge in the same cycle
    wr(2, 32'h0E);
    pad_in[2] = 1'b1; cyc(6);
    pad_in[2] = 1'b0; cyc(6);
    @(negedge clk); pad_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(2); bus_wdata = 32'h1E;
    @(negedge clk); bus_wr = 1'b0;
    rdreg(2, rd);  chk("R9 edge wins over clear", {31'd0, rd[4]}, 1);
    wr(2, 32'h1E); rdreg(2, rd);
    chk("R8 later clear", {31'd0, rd[4]}, 0);
    wr(2, 0); pad_in[2] = 1'b0; cyc(6);

    // R3 output path
    wr(N + 1, 32'hFF);
    rdreg(N + 1, rd); chk("R2 padsel readback", rd, 32'hFF);
    wr(3, 32'h60); cyc(2);
    chk("R3 oe on", {31'd0, pad_oe[3]}, 1);
    chk("R3 data one", {31'd0, pad_out[3]}, 1);
    wr(3, 32'h20); cyc(2);
    chk("R3 data zero", {31'd0, pad_out[3]}, 0);
    wr(3, 32'h40); cyc(2);
    chk("R3 oe off", {31'd0, pad_oe[3]}, 0);

    // R5 pulls
    wr(4, 32'h300); cyc(2);
    chk("R5 pull up", {30'd0, pad_pull_en[4], pad_pull_up[4]}, 2'b11);
    wr(4, 32'h100); cyc(2);
    chk("R5 pull down", {30'd0, pad_pull_en[4], pad_pull_up[4]}, 2'b10);

    // R4 level readback
    pad_in[5] = 1'b1; cyc(4);
    rdreg(5, rd); chk("R4 level high", {31'd0, rd[7]}, 1);
    pad_in[5] = 1'b0; cyc(4);
    rdreg(5, rd); chk("R4 level low", {31'd0, rd[7]}, 0);

    // R12 alternate function on pin 3
    alt_out = 8'hFF; alt_oe = 8'h08;
    wr(N + 1, 32'hF7); pad_in[3] = 1'b1; pad_in[6] = 1'b1; cyc(4);
    chk("R12 alt oe", {31'd0, pad_oe[3]}, 1);
    chk("R12 alt out", {31'd0, pad_out[3]}, 1);
    chk("R12 alt_in", {24'd0, alt_in}, 32'h08);
    chk("R12 gpio pin out", {31'd0, pad_out[0]}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule